// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on separate, unrelated clocks. Its depth is chosen by a parameter (64, 256, 512, 1024, 2048 or 4096 words). Four flags report fill state: full and a programmable near-full on the write side, and empty and a programmable near-empty on the read side.

A dual-purpose write-side pin selects the operating mode. It is sampled while reset is held.

- If the pin is high during reset, the block is in plain mode. The pin then acts as a second write enable.
- If the pin is low during reset, the block is in offset-load mode. The pin then acts as a load strobe. With the strobe high, the two near-flag thresholds are written through the data input and read back through the data output. With the strobe low, ordinary words pass through the buffer.

Reads need two read enables, and an output enable gates the data output.

Pointers cross between the clock domains as Gray codes through two-flop synchronizers. Full is derived on the write clock and empty on the read clock. The load strobe and the mode are treated as quasi-static by the read side: they change only while no read is in flight.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: Words written on `wclk` come out on `dout` in the order they were written, across independent write and read clocks. The data path is 9 bits wide.
- R2: A word is written on a `wclk` rising edge when `wr_en_a` is 1 and the FIFO is not full, and one of the following holds:
  - in plain mode, `wr_aux_load` is 1;
  - in offset-load mode, `wr_aux_load` is 0.
  In every other case nothing is written.
- R3: A word is read on an `rclk` rising edge when `rd_en_a` and `rd_en_b` are both 1 and the FIFO is not empty. The word appears on `dout` after that edge. With either enable at 0, nothing is read.
- R4: `full` is 1 exactly when DEPTH words are held, as seen by the write side. `empty` is 1 exactly when no word is held, as seen by the read side.
- R5: A write attempted while full and a read attempted while empty are ignored. No word is lost or duplicated, and `dout` keeps its value.
- R6: The near-full and near-empty flags follow the fill level and the stored thresholds:
  - `almost_full` is 1 when the free space (DEPTH minus words held) is at or below the near-full threshold;
  - `almost_empty` is 1 when the words held are at or below the near-empty threshold.
- R7: After reset, the FIFO holds no words. `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, `dout` is 0, and both thresholds are 7.
- R8: When `oe` is 0, `dout` is 0. When `oe` returns to 1, the held read word shows again. `oe` never affects reading.
- R9: In offset-load mode, each `wclk` edge with `wr_aux_load` and `wr_en_a` both 1 stores `din` into one threshold. The order is near-empty first, then near-full, and then it alternates. No word enters the buffer.
- R10: In offset-load mode, each `rclk` edge with `wr_aux_load`, `rd_en_a` and `rd_en_b` all 1 places one threshold on `dout`, in the same alternating order starting with near-empty. The buffered words are not consumed.
- R11: The value of `wr_aux_load` on `wclk` edges while `rst_n` is 0 fixes the mode until the next reset: 0 selects offset-load mode and 1 selects plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both sides |
| wclk | input | 1 | Write clock |
| wr_en_a | input | 1 | First write enable, active high |
| wr_aux_load | input | 1 | Sampled at reset for the mode; afterwards either the second write enable or the threshold load strobe |
| din | input | 9 | Write data, or threshold value during a load |
| full | output | 1 | Buffer holds DEPTH words |
| almost_full | output | 1 | Free space at or below the near-full threshold |
| rclk | input | 1 | Read clock |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| oe | input | 1 | Output enable; 0 forces `dout` to zero |
| dout | output | 9 | Read word or threshold read-back |
| empty | output | 1 | Buffer holds no word |
| almost_empty | output | 1 | Words held at or below the near-empty threshold |

## Verification
Two cases put a push and a pop in the same cycle: a concurrent writer and reader run on their two clocks, and a pop of the last word races against a fresh push. In both, the near-empty and empty flags must settle to the true level with every word delivered once and in order, which a queue-based scoreboard judges at each read edge.

The second overlap is a threshold read-back arriving while the buffer holds data. The bench issues the strobed read mid-stream and then requires that the next ordinary read still returns the word at the head of the queue.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  localparam int unsigned DATA_W = 9;
  localparam logic [DATA_W-1:0] OFS_DEFAULT = 9'd7;

  typedef enum logic {SEL_NEAR_EMPTY = 1'b0, SEL_NEAR_FULL = 1'b1} ofs_sel_e;

  // Threshold test shared by both fill flags: amount <= limit.
  function automatic logic at_or_below(int unsigned amount, logic [DATA_W-1:0] limit);
    return amount <= 32'(limit);
  endfunction

  function automatic ofs_sel_e next_sel(ofs_sel_e s);
    return (s == SEL_NEAR_EMPTY) ? SEL_NEAR_FULL : SEL_NEAR_EMPTY;
  endfunction
endpackage

// File: rtl/dcff_gray_cross.sv
module dcff_gray_cross #(
  parameter int unsigned W = 7
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bin_nxt,
  output logic [W-1:0] dst_bin
);
  function automatic logic [W-1:0] to_gray(logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] to_bin(logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] g_src, g_meta, g_dst;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) g_src <= '0;
    else        g_src <= to_gray(src_bin_nxt);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      g_meta <= '0;
      g_dst  <= '0;
    end else begin
      g_meta <= g_src;
      g_dst  <= g_meta;
    end
  end

  assign dst_bin = to_bin(g_dst);

  // R1: the crossing code moves by at most one bit per source edge
  p_gray_step_r1: assert property (@(posedge src_clk) disable iff (!rst_n)
    $onehot0(g_src ^ $past(g_src)));
endmodule

// File: rtl/dcff_ram.sv
module dcff_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6,
  parameter int unsigned DW    = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcff_wr_side.sv
module dcff_wr_side
  import dcff_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PW    = 7
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              load_mode,
  input  logic              wr_en_a,
  input  logic              aux_pin,
  input  logic [DATA_W-1:0] din,
  input  logic [PW-1:0]     rbin_w,
  output logic              wr_fire,
  output logic [PW-1:0]     wbin,
  output logic [PW-1:0]     wbin_nxt,
  output logic              full,
  output logic              almost_full,
  output logic [DATA_W-1:0] ae_off,
  output logic [DATA_W-1:0] af_off
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic          wr_req, ofs_load;
  logic [PW-1:0] used, free;
  ofs_sel_e      wsel;

  // Named events for assertions and the memory port
  assign wr_req   = wr_en_a & (load_mode ? ~aux_pin : aux_pin);
  assign ofs_load = wr_en_a & load_mode & aux_pin;
  assign wr_fire  = wr_req & ~full;

  assign used        = wbin - rbin_w;
  assign free        = CAP - used;
  assign full        = (used == CAP);
  assign almost_full = at_or_below(32'(free), af_off);
  assign wbin_nxt    = wbin + {{(PW-1){1'b0}}, wr_fire};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wbin <= '0;
    else        wbin <= wbin_nxt;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= OFS_DEFAULT;
      af_off <= OFS_DEFAULT;
      wsel   <= SEL_NEAR_EMPTY;
    end else if (ofs_load) begin
      if (wsel == SEL_NEAR_EMPTY) ae_off <= din;
      else                        af_off <= din;
      wsel <= next_sel(wsel);
    end
  end

  // R5: a write attempt while full leaves the write pointer alone
  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_req) |=> (wbin == $past(wbin)));
  // R1: an accepted write advances the pointer by exactly one
  p_push_step_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> (wbin == $past(wbin) + PW'(1)));
  // R6: zero free space is always within the near-full threshold
  p_full_near_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  // R9: a threshold load never pushes a word
  p_load_no_push_r9: assert property (@(posedge wclk) disable iff (!rst_n)
    ofs_load |=> $stable(wbin));
endmodule

// File: rtl/dcff_rd_side.sv
module dcff_rd_side
  import dcff_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PW    = 7
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load_mode,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              aux_pin,
  input  logic [PW-1:0]     wbin_r,
  input  logic [DATA_W-1:0] mem_q,
  input  logic [DATA_W-1:0] ae_off,
  input  logic [DATA_W-1:0] af_off,
  output logic [PW-1:0]     rbin,
  output logic [PW-1:0]     rbin_nxt,
  output logic              empty,
  output logic              almost_empty,
  output logic [DATA_W-1:0] q_reg
);
  logic          both_en, ofs_peek, rd_req, rd_fire;
  logic [PW-1:0] count;
  ofs_sel_e      rsel;

  assign both_en  = rd_en_a & rd_en_b;
  assign ofs_peek = both_en & load_mode & aux_pin;
  assign rd_req   = both_en & ~ofs_peek;
  assign rd_fire  = rd_req & ~empty;

  assign count        = wbin_r - rbin;
  assign empty        = (count == '0);
  assign almost_empty = at_or_below(32'(count), ae_off);
  assign rbin_nxt     = rbin + {{(PW-1){1'b0}}, rd_fire};

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      q_reg <= '0;
      rsel  <= SEL_NEAR_EMPTY;
    end else begin
      rbin <= rbin_nxt;
      if (rd_fire) begin
        q_reg <= mem_q;
      end else if (ofs_peek) begin
        q_reg <= (rsel == SEL_NEAR_EMPTY) ? ae_off : af_off;
        rsel  <= next_sel(rsel);
      end
    end
  end

  // R5: a read attempt while empty leaves the read pointer alone
  p_no_underflow_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_req) |=> (rbin == $past(rbin)));
  // R6: an empty buffer is always within the near-empty threshold
  p_empty_near_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
  // R10: a threshold read-back consumes no word
  p_peek_no_pop_r10: assert property (@(posedge rclk) disable iff (!rst_n)
    ofs_peek |=> $stable(rbin));
  // R4: the synchronized write pointer never runs more than DEPTH ahead
  p_count_bound_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    32'(count) <= DEPTH);
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import dcff_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              wr_en_a,
  input  logic              wr_aux_load,
  input  logic [DATA_W-1:0] din,
  output logic              full,
  output logic              almost_full,
  input  logic              rclk,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              almost_empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic              load_mode, wr_fire;
  logic [PW-1:0]     wbin, wbin_nxt, rbin, rbin_nxt, wbin_at_r, rbin_at_w;
  logic [DATA_W-1:0] ae_off, af_off, mem_q, q_reg;

  // Mode capture: held while reset is low, frozen afterwards
  always_ff @(posedge wclk) begin
    if (!rst_n) load_mode <= ~wr_aux_load;
  end

  dcff_wr_side #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .load_mode(load_mode), .wr_en_a(wr_en_a),
    .aux_pin(wr_aux_load), .din(din), .rbin_w(rbin_at_w), .wr_fire(wr_fire),
    .wbin(wbin), .wbin_nxt(wbin_nxt), .full(full), .almost_full(almost_full),
    .ae_off(ae_off), .af_off(af_off)
  );

  dcff_rd_side #(.DEPTH(DEPTH), .PW(PW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .load_mode(load_mode), .rd_en_a(rd_en_a),
    .rd_en_b(rd_en_b), .aux_pin(wr_aux_load), .wbin_r(wbin_at_r), .mem_q(mem_q),
    .ae_off(ae_off), .af_off(af_off), .rbin(rbin), .rbin_nxt(rbin_nxt),
    .empty(empty), .almost_empty(almost_empty), .q_reg(q_reg)
  );

  dcff_gray_cross #(.W(PW)) u_w2r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n),
    .src_bin_nxt(wbin_nxt), .dst_bin(wbin_at_r)
  );

  dcff_gray_cross #(.W(PW)) u_r2w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n),
    .src_bin_nxt(rbin_nxt), .dst_bin(rbin_at_w)
  );

  dcff_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DATA_W)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(din),
    .raddr(rbin[AW-1:0]), .rdata(mem_q)
  );

  assign dout = oe ? q_reg : '0;

  // R11: the captured mode does not change outside reset
  p_mode_hold_r11: assert property (@(posedge wclk) disable iff (!rst_n)
    $stable(load_mode));
endmodule

// File: tb/dual_clock_flag_fifo_tb.sv
module dual_clock_flag_fifo_tb;
  localparam int unsigned DEPTH = 64;

  logic       rst_n = 0, wclk = 0, rclk = 0;
  logic       wr_en_a = 0, wr_aux_load = 1, rd_en_a = 0, rd_en_b = 0, oe = 1;
  logic [8:0] din = '0;
  logic       full, almost_full, empty, almost_empty;
  logic [8:0] dout;

  int         n_cmp = 0, n_bad = 0;
  logic [8:0] sb[$];
  logic       mon_armed = 0, ld_mode = 0;

  always #2 wclk = ~wclk;   // 250 MHz write clock
  always #3 rclk = ~rclk;

  dual_clock_flag_fifo #(.DEPTH(DEPTH)) u_dut (
    .rst_n(rst_n), .wclk(wclk), .wr_en_a(wr_en_a), .wr_aux_load(wr_aux_load),
    .din(din), .full(full), .almost_full(almost_full), .rclk(rclk),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .oe(oe), .dout(dout),
    .empty(empty), .almost_empty(almost_empty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  // Monitor: a read seen armed before an rclk edge is compared at the next falling edge
  always @(negedge rclk) begin
    if (mon_armed) begin
      if (sb.size() == 0) check("R1 unexpected word", 32'(dout), 32'h1ff);
      else check("R1/R3 read order", 32'(dout), 32'(sb.pop_front()));
    end
    mon_armed = rst_n && rd_en_a && rd_en_b && !empty && !(ld_mode && wr_aux_load);
  end

  task automatic do_reset(input logic mode_pin);
    wr_aux_load = mode_pin;
    rst_n = 0;
    repeat (4) @(posedge wclk);
    #1 rst_n = 1;
    ld_mode = !mode_pin;
    if (!ld_mode) wr_aux_load = 1;
    repeat (2) @(posedge rclk);
    #1;
  endtask

  task automatic push(input logic [8:0] v);
    @(posedge wclk); #1;
    while (full) begin @(posedge wclk); #1; end
    wr_en_a = 1; din = v; sb.push_back(v);
    @(posedge wclk); #1;
    wr_en_a = 0;
  endtask

  task automatic pop();
    @(posedge rclk); #1;
    while (empty) begin @(posedge rclk); #1; end
    rd_en_a = 1; rd_en_b = 1;
    @(posedge rclk); #1;
    rd_en_a = 0; rd_en_b = 0;
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    @(posedge wclk); #1;
  endtask

  task automatic peek_ofs(input logic [8:0] exp, input string tag);
    @(posedge rclk); #1;
    wr_aux_load = 1; rd_en_a = 1; rd_en_b = 1;
    @(posedge rclk); #1;
    rd_en_a = 0; rd_en_b = 0; wr_aux_load = 0;
    check(tag, 32'(dout), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // ---------- plain mode ----------
    do_reset(1'b1);
    check("R7 empty at reset", 32'(empty), 1);
    check("R7 almost_empty at reset", 32'(almost_empty), 1);
    check("R7 full at reset", 32'(full), 0);
    check("R7 almost_full at reset", 32'(almost_full), 0);
    check("R7 dout at reset", 32'(dout), 0);

    // R2: second write enable low blocks the write
    wr_aux_load = 0;
    @(posedge wclk); #1 wr_en_a = 1; din = 9'h1aa;
    repeat (3) @(posedge wclk); #1 wr_en_a = 0; wr_aux_load = 1;
    settle();
    check("R2 write blocked by second enable", 32'(empty), 1);

    // R6: near-empty threshold 7 at levels 8 and 7
    for (int i = 0; i < 10; i++) push(pat(i));
    repeat (2) pop();
    settle();
    check("R6 almost_empty at 8 words", 32'(almost_empty), 0);
    pop();
    settle();
    check("R6 almost_empty at 7 words", 32'(almost_empty), 1);
    repeat (7) pop();
    settle();
    check("R4 empty after drain", 32'(empty), 1);

    // R3: one read enable low does not read
    push(9'h0c3);
    settle();
    @(posedge rclk); #1 rd_en_a = 1; rd_en_b = 0;
    repeat (3) @(posedge rclk); #1 rd_en_a = 0;
    settle();
    check("R3 single enable no read", 32'(empty), 0);
    pop();
    settle();

    // R5: reads while empty are ignored
    @(posedge rclk); #1 rd_en_a = 1; rd_en_b = 1;
    repeat (3) @(posedge rclk); #1 rd_en_a = 0; rd_en_b = 0;
    check("R5 dout kept on empty read", 32'(dout), 32'h0c3);
    push(9'h055);
    pop();
    settle();

    // R8: output enable
    oe = 0; #1;
    check("R8 dout zero with oe low", 32'(dout), 0);
    oe = 1; #1;
    check("R8 dout restored with oe high", 32'(dout), 32'h055);

    // R4/R5/R6: fill, overflow attempt, near-full threshold
    for (int i = 0; i < DEPTH; i++) push(pat(i + 100));
    settle();
    check("R4 full at DEPTH", 32'(full), 1);
    check("R6 almost_full when full", 32'(almost_full), 1);
    @(posedge wclk); #1 wr_en_a = 1; din = 9'h1ff;
    repeat (3) @(posedge wclk); #1 wr_en_a = 0;
    pop();
    settle();
    check("R4 full clears after one read", 32'(full), 0);
    repeat (6) pop();
    settle();
    check("R6 almost_full at free 7", 32'(almost_full), 1);
    pop();
    settle();
    check("R6 almost_full at free 8", 32'(almost_full), 0);
    repeat (DEPTH - 8) pop();
    settle();
    check("R5 overflow word not stored", 32'(empty), 1);

    // R1: concurrent writer and reader
    fork
      for (int i = 0; i < 100; i++) push(pat(i + 300));
      repeat (100) pop();
    join
    settle();
    check("R1 concurrent stream drained", 32'(sb.size()), 0);
    check("R4 empty after stream", 32'(empty), 1);

    // ---------- offset-load mode ----------
    do_reset(1'b0);
    check("R7 empty after second reset", 32'(empty), 1);
    peek_ofs(9'd7, "R7/R10 default near-empty threshold");
    peek_ofs(9'd7, "R7/R10 default near-full threshold");

    // R9: write thresholds 3 then 5
    @(posedge wclk); #1 wr_aux_load = 1; wr_en_a = 1; din = 9'd3;
    @(posedge wclk); #1 din = 9'd5;
    @(posedge wclk); #1 wr_en_a = 0; wr_aux_load = 0;
    settle();
    check("R9 threshold load pushes nothing", 32'(empty), 1);
    peek_ofs(9'd3, "R9/R10 near-empty threshold readback");
    peek_ofs(9'd5, "R9/R10 near-full threshold readback");

    // R11: load strobe low writes data in this mode
    for (int i = 0; i < 4; i++) push(pat(i + 500));
    settle();
    check("R11 load-mode write accepted", 32'(empty), 0);
    check("R6 almost_empty at 4 over 3", 32'(almost_empty), 0);
    pop();
    settle();
    check("R6 almost_empty at 3 over 3", 32'(almost_empty), 1);

    for (int i = 0; i < 56; i++) push(pat(i + 600));
    settle();
    check("R6 almost_full free 5 over 5", 32'(almost_full), 1);
    peek_ofs(9'd3, "R10 readback with data held");
    pop();
    settle();
    check("R6 almost_full free 6 over 5", 32'(almost_full), 0);
    peek_ofs(9'd5, "R10 second readback with data held");
    repeat (58) pop();
    settle();
    check("R10 all words delivered", 32'(sb.size()), 0);
    check("R4 empty at end", 32'(empty), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule